// File: doc/BRIEF.md
# Dual-Lane Serial Frame Transmitter

This block turns a parallel frame request into a serial bit stream on one or two data lanes, together with a forwarded bit clock. A frame holds an opening marker, a 4-bit frame type, a variable number of 16-bit data words, an 8-bit CRC supplied by the requester, a 4-bit tag and a closing marker. The request is taken with a valid/ready handshake. The CRC is not computed here.

In single-lane mode every bit leaves on the primary lane. In two-lane mode the data words and the CRC are split across the lanes, so a word needs half as many bit-times. The second lane carries the odd-numbered bits and the primary lane carries the even-numbered bits. The framing fields are sent at full width, with the same value on both lanes. Between frames the clock and both lanes rest high.

Top module: `dlane_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is being sent, `ser_clk`, `ser_d0` and `ser_d1` are all 1 and `req_ready` is 1.
- R2: A request is accepted on a rising `clk` edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the frame's last bit-time has completed. `req_valid` has no effect while `req_ready` is 0.
- R3: The field order is: opening marker 4'b1001, `req_type`, `req_nwords` data words, `req_crc`, `req_tag`, closing marker 4'b0110. Word 0 is `req_data[15:0]` and is sent first. Word i is `req_data[16*i+15:16*i]`. Each field leaves most significant bit first.
- R4: Each bit-time lasts two `clk` cycles, `ser_clk` low then high. The lanes change only together with the low phase and hold steady across the rising edge of `ser_clk`, where a receiver samples them. `req_ready` is 0 for exactly two cycles per bit-time of the frame.
- R5: With `lane_mode`=0 latched, every field bit goes out on `ser_d0` and `ser_d1` stays at 1 for the whole frame.
- R6: With `lane_mode`=1 latched, each data word takes 8 bit-times and the CRC takes 4. In bit-time k of a word, `ser_d1` carries bit 15-2k and `ser_d0` carries bit 14-2k. For the CRC, `ser_d1` carries bit 7-2k and `ser_d0` carries bit 6-2k.
- R7: With `lane_mode`=1 latched, the markers, the type and the tag take 4 bit-times each, and `ser_d1` equals `ser_d0` during them.
- R8: `lane_mode` and every request field are captured at acceptance. Changing them during a frame does not alter that frame.
- R9: A word count of 0 sends the CRC right after the type. A word count above MAX_WORDS is treated as MAX_WORDS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Frame request present |
| req_ready | output | 1 | Transmitter can accept a request |
| req_type | input | 4 | Frame type field |
| req_tag | input | 4 | Tag field |
| req_nwords | input | $clog2(MAX_WORDS+1) | Number of data words |
| req_data | input | 16*MAX_WORDS | Data words, word 0 in the low bits |
| req_crc | input | 8 | CRC byte supplied by the requester |
| lane_mode | input | 1 | 0 = single lane, 1 = two lanes |
| ser_clk | output | 1 | Forwarded bit clock |
| ser_d0 | output | 1 | Primary data lane |
| ser_d1 | output | 1 | Second data lane |

## Verification
The bench builds the block with MAX_WORDS=5, so the word-count input is 3 bits wide. This gives frames with zero words, frames at the full five-word limit, and the counts 6 and 7, which the block must clamp. In both lane modes the longest frame stays well under the run limit, so many random frames fit alongside the directed ones. Among the directed frames are some where the lane mode, the request fields and `req_valid` change during transmission.

// File: rtl/dlft_pkg.sv
package dlft_pkg;
  typedef enum logic [2:0] {
    FLD_IDLE,
    FLD_OPEN,
    FLD_KIND,
    FLD_WORD,
    FLD_CHK,
    FLD_LABEL,
    FLD_CLOSE
  } fld_e;

  localparam int HDR_W = 4;
  localparam logic [HDR_W-1:0] OPEN_MARK  = 4'b1001;
  localparam logic [HDR_W-1:0] CLOSE_MARK = 4'b0110;
endpackage

// File: rtl/dlft_seq.sv
module dlft_seq
  import dlft_pkg::*;
#(
  parameter int MAX_WORDS = 4,
  parameter int WORD_W    = 16,
  parameter int CRC_W     = 8,
  localparam int NW_W     = $clog2(MAX_WORDS + 1),
  localparam int BI_W     = $clog2(WORD_W),
  localparam int LEN_W    = BI_W + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            dual,
  input  logic [NW_W-1:0] nwords,
  output fld_e            field,
  output logic [BI_W-1:0] bit_idx,
  output logic [NW_W-1:0] word_idx,
  output logic            phase,
  output logic            busy
);
  logic [LEN_W-1:0] len;
  logic             last_bit;
  logic             last_word;
  fld_e             nxt;

  always_comb begin
    case (field)
      FLD_WORD: len = dual ? LEN_W'(WORD_W / 2) : LEN_W'(WORD_W);
      FLD_CHK:  len = dual ? LEN_W'(CRC_W / 2)  : LEN_W'(CRC_W);
      FLD_IDLE: len = LEN_W'(1);
      default:  len = LEN_W'(HDR_W);
    endcase
  end

  assign last_bit  = ({1'b0, bit_idx} == (len - LEN_W'(1)));
  assign last_word = ((word_idx + NW_W'(1)) == nwords);

  always_comb begin
    case (field)
      FLD_OPEN:  nxt = FLD_KIND;
      FLD_KIND:  nxt = (nwords == '0) ? FLD_CHK : FLD_WORD;
      FLD_WORD:  nxt = last_word ? FLD_CHK : FLD_WORD;
      FLD_CHK:   nxt = FLD_LABEL;
      FLD_LABEL: nxt = FLD_CLOSE;
      default:   nxt = FLD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      field    <= FLD_IDLE;
      bit_idx  <= '0;
      word_idx <= '0;
      phase    <= 1'b0;
    end else if (field == FLD_IDLE) begin
      if (start) begin
        field    <= FLD_OPEN;
        bit_idx  <= '0;
        word_idx <= '0;
        phase    <= 1'b0;
      end
    end else begin
      phase <= ~phase;
      if (phase) begin
        if (last_bit) begin
          bit_idx <= '0;
          field   <= nxt;
          if (field == FLD_WORD && !last_word)
            word_idx <= word_idx + NW_W'(1);
        end else begin
          bit_idx <= bit_idx + BI_W'(1);
        end
      end
    end
  end

  assign busy = (field != FLD_IDLE);
endmodule

// File: rtl/dlft_lane_split.sv
module dlft_lane_split
  import dlft_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CRC_W  = 8,
  localparam int BI_W  = $clog2(WORD_W)
) (
  input  fld_e              field,
  input  logic [BI_W-1:0]   bit_idx,
  input  logic              dual,
  input  logic [HDR_W-1:0]  kind,
  input  logic [HDR_W-1:0]  label,
  input  logic [WORD_W-1:0] word,
  input  logic [CRC_W-1:0]  crc,
  output logic              d0,
  output logic              d1
);
  logic [BI_W:0]       sh;
  logic [WORD_W-1:0]   word_sh;
  logic [CRC_W-1:0]    crc_sh;
  logic [HDR_W-1:0]    hdr;
  logic [HDR_W-1:0]    hdr_sh;
  logic                pay_hi;
  logic                pay_lo;

  assign sh      = dual ? {bit_idx, 1'b0} : {1'b0, bit_idx};
  assign word_sh = word << sh;
  assign crc_sh  = crc << sh;

  always_comb begin
    case (field)
      FLD_OPEN:  hdr = OPEN_MARK;
      FLD_KIND:  hdr = kind;
      FLD_LABEL: hdr = label;
      FLD_CLOSE: hdr = CLOSE_MARK;
      default:   hdr = '1;
    endcase
  end

  assign hdr_sh = hdr << bit_idx;

  always_comb begin
    if (field == FLD_CHK) begin
      pay_hi = crc_sh[CRC_W-1];
      pay_lo = crc_sh[CRC_W-2];
    end else begin
      pay_hi = word_sh[WORD_W-1];
      pay_lo = word_sh[WORD_W-2];
    end
  end

  always_comb begin
    if (field == FLD_WORD || field == FLD_CHK) begin
      if (dual) begin
        d1 = pay_hi;
        d0 = pay_lo;
      end else begin
        d1 = 1'b1;
        d0 = pay_hi;
      end
    end else begin
      d0 = hdr_sh[HDR_W-1];
      d1 = dual ? hdr_sh[HDR_W-1] : 1'b1;
    end
  end
endmodule

// File: rtl/dlane_frame_tx.sv
module dlane_frame_tx
  import dlft_pkg::*;
#(
  parameter int MAX_WORDS = 4,
  parameter int WORD_W    = 16,
  parameter int CRC_W     = 8,
  localparam int NW_W     = $clog2(MAX_WORDS + 1),
  localparam int BI_W     = $clog2(WORD_W)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [HDR_W-1:0]            req_type,
  input  logic [HDR_W-1:0]            req_tag,
  input  logic [NW_W-1:0]             req_nwords,
  input  logic [WORD_W*MAX_WORDS-1:0] req_data,
  input  logic [CRC_W-1:0]            req_crc,
  input  logic                        lane_mode,
  output logic                        ser_clk,
  output logic                        ser_d0,
  output logic                        ser_d1
);
  localparam logic [NW_W-1:0] NW_LIMIT = NW_W'(MAX_WORDS);

  logic                        accept;
  logic [NW_W-1:0]             nw_clamp;
  logic [HDR_W-1:0]            cap_type;
  logic [HDR_W-1:0]            cap_tag;
  logic [NW_W-1:0]             cap_nw;
  logic [WORD_W*MAX_WORDS-1:0] cap_data;
  logic [CRC_W-1:0]            cap_crc;
  logic                        cap_dual;

  fld_e                        field;
  logic [BI_W-1:0]             bit_idx;
  logic [NW_W-1:0]             word_idx;
  logic                        phase;
  logic                        busy;
  logic [WORD_W-1:0]           words [MAX_WORDS];
  logic [WORD_W-1:0]           cur_word;
  logic                        nxt_d0;
  logic                        nxt_d1;

  fld_e                        out_fld_q;
  logic                        out_dual_q;

  assign req_ready = ~busy;
  assign accept    = req_valid & req_ready;
  assign nw_clamp  = (req_nwords > NW_LIMIT) ? NW_LIMIT : req_nwords;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_nw   <= '0;
      cap_dual <= 1'b0;
    end else if (accept) begin
      cap_nw   <= nw_clamp;
      cap_dual <= lane_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      cap_type <= req_type;
      cap_tag  <= req_tag;
      cap_data <= req_data;
      cap_crc  <= req_crc;
    end
  end

  for (genvar gi = 0; gi < MAX_WORDS; gi++) begin : g_word
    assign words[gi] = cap_data[gi*WORD_W +: WORD_W];
  end

  assign cur_word = words[word_idx];

  dlft_seq #(
    .MAX_WORDS (MAX_WORDS),
    .WORD_W    (WORD_W),
    .CRC_W     (CRC_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .dual     (cap_dual),
    .nwords   (cap_nw),
    .field    (field),
    .bit_idx  (bit_idx),
    .word_idx (word_idx),
    .phase    (phase),
    .busy     (busy)
  );

  dlft_lane_split #(
    .WORD_W (WORD_W),
    .CRC_W  (CRC_W)
  ) u_split (
    .field   (field),
    .bit_idx (bit_idx),
    .dual    (cap_dual),
    .kind    (cap_type),
    .label   (cap_tag),
    .word    (cur_word),
    .crc     (cap_crc),
    .d0      (nxt_d0),
    .d1      (nxt_d1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_clk    <= 1'b1;
      ser_d0     <= 1'b1;
      ser_d1     <= 1'b1;
      out_fld_q  <= FLD_IDLE;
      out_dual_q <= 1'b0;
    end else if (busy) begin
      ser_clk    <= phase;
      ser_d0     <= nxt_d0;
      ser_d1     <= nxt_d1;
      out_fld_q  <= field;
      out_dual_q <= cap_dual;
    end else begin
      ser_clk    <= 1'b1;
      ser_d0     <= 1'b1;
      ser_d1     <= 1'b1;
      out_fld_q  <= FLD_IDLE;
      out_dual_q <= cap_dual;
    end
  end
endmodule

// File: rtl/dlft_checker.sv
module dlft_checker
  import dlft_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic ser_clk,
  input logic ser_d0,
  input logic ser_d1,
  input fld_e out_fld,
  input logic out_dual
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    $past(req_ready) |-> (ser_clk && ser_d0 && ser_d1));

  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_clk_toggle_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(req_ready) && !$past(req_ready, 2)) |-> (ser_clk != $past(ser_clk)));

  assert_lane_stable_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk) |-> ($stable(ser_d0) && $stable(ser_d1)));

  assert_single_d1_high_R5: assert property (@(posedge clk) disable iff (rst)
    (!out_dual && out_fld != FLD_IDLE) |-> ser_d1);

  assert_frame_copy_R7: assert property (@(posedge clk) disable iff (rst)
    (out_dual && (out_fld == FLD_OPEN || out_fld == FLD_KIND ||
                  out_fld == FLD_LABEL || out_fld == FLD_CLOSE)) |-> (ser_d1 == ser_d0));
endmodule

bind dlane_frame_tx dlft_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .ser_clk   (ser_clk),
  .ser_d0    (ser_d0),
  .ser_d1    (ser_d1),
  .out_fld   (out_fld_q),
  .out_dual  (out_dual_q)
);

// File: tb/dlane_frame_tx_test.sv
module dlane_frame_tx_test;
  localparam int MAXW = 5;
  localparam int NWW  = $clog2(MAXW + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [3:0]        req_type = '0;
  logic [3:0]        req_tag = '0;
  logic [NWW-1:0]    req_nwords = '0;
  logic [16*MAXW-1:0] req_data = '0;
  logic [7:0]        req_crc = '0;
  logic              lane_mode = 1'b0;
  logic              ser_clk, ser_d0, ser_d1;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [1:0] exp_q [0:255];
  int         exp_n;
  logic [1:0] got_q [0:255];
  int         got_n = 0;
  logic       prev_sclk = 1'b1;

  always #2 clk = ~clk;

  dlane_frame_tx #(.MAX_WORDS(MAXW)) uut (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_type   (req_type),
    .req_tag    (req_tag),
    .req_nwords (req_nwords),
    .req_data   (req_data),
    .req_crc    (req_crc),
    .lane_mode  (lane_mode),
    .ser_clk    (ser_clk),
    .ser_d0     (ser_d0),
    .ser_d1     (ser_d1)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (ser_clk && !prev_sclk && got_n < 256) begin
        got_q[got_n] = {ser_d1, ser_d0};
        got_n = got_n + 1;
      end
      prev_sclk = ser_clk;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic d1, input logic d0);
    exp_q[exp_n] = {d1, d0};
    exp_n++;
  endtask

  task automatic push_hdr(input logic [3:0] v, input bit dual);
    for (int k = 3; k >= 0; k--) push(dual ? v[k] : 1'b1, v[k]);
  endtask

  task automatic build_exp(input logic [3:0] ty, input logic [3:0] tg,
                           input logic [NWW-1:0] nw, input logic [16*MAXW-1:0] data,
                           input logic [7:0] crc, input bit dual);
    int nwc;
    logic [15:0] w;
    exp_n = 0;
    nwc = (int'(nw) > MAXW) ? MAXW : int'(nw);
    push_hdr(4'b1001, dual);
    push_hdr(ty, dual);
    for (int i = 0; i < nwc; i++) begin
      w = data[16*i +: 16];
      if (dual) for (int k = 0; k < 8; k++) push(w[15-2*k], w[14-2*k]);
      else      for (int k = 0; k < 16; k++) push(1'b1, w[15-k]);
    end
    if (dual) for (int k = 0; k < 4; k++) push(crc[7-2*k], crc[6-2*k]);
    else      for (int k = 0; k < 8; k++) push(1'b1, crc[7-k]);
    push_hdr(tg, dual);
    push_hdr(4'b0110, dual);
  endtask

  task automatic run_frame(input logic [3:0] ty, input logic [3:0] tg,
                           input logic [NWW-1:0] nw, input logic [16*MAXW-1:0] data,
                           input logic [7:0] crc, input bit dual, input bit disturb,
                           input string tag);
    int busy_cyc;
    int bad;
    int first_bad;
    while (!req_ready) @(negedge clk);
    build_exp(ty, tg, nw, data, crc, dual);
    got_n = 0;
    req_type = ty; req_tag = tg; req_nwords = nw; req_data = data;
    req_crc = crc; lane_mode = dual; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    // R2: ready must drop right after acceptance
    chk(req_ready == 1'b0, "R2 ready after accept", int'(req_ready), 0);
    busy_cyc = 0;
    if (disturb) begin
      // R8: change mode and fields, keep valid up while busy
      lane_mode = ~dual; req_type = ~ty; req_tag = ~tg; req_crc = ~crc;
      req_data = ~data; req_nwords = '0; req_valid = 1'b1;
      for (int i = 0; i < 10; i++) begin
        if (!req_ready) busy_cyc++;
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
    while (!req_ready && busy_cyc < 1000) begin
      busy_cyc++;
      @(negedge clk);
    end
    // R4: two cycles per bit-time
    chk(busy_cyc == 2 * exp_n, "R4 busy cycles", busy_cyc, 2 * exp_n);
    @(negedge clk);
    // R1: rest level after the frame
    chk(ser_clk && ser_d0 && ser_d1, "R1 idle after frame",
        int'({ser_clk, ser_d0, ser_d1}), 7);
    // R3: number of bit-times
    chk(got_n == exp_n, {tag, " bit-time count"}, got_n, exp_n);
    bad = 0; first_bad = -1;
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      if (got_q[i] !== exp_q[i]) begin
        if (first_bad < 0) first_bad = i;
        bad++;
      end
    end
    if (first_bad >= 0)
      chk(1'b0, {tag, " lane bits"}, int'(got_q[first_bad]), int'(exp_q[first_bad]));
    else
      chk(1'b1, {tag, " lane bits"}, 0, 0);
  endtask

  function automatic logic [16*MAXW-1:0] rnd_data();
    logic [16*MAXW-1:0] d;
    d = {$urandom(), $urandom(), $urandom()};
    return d;
  endfunction

  initial begin
    void'($urandom(32'h1F2E3D));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(ser_clk && ser_d0 && ser_d1, "R1 reset outputs", int'({ser_clk, ser_d0, ser_d1}), 7);
    chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);

    // R3 R5: single lane, two words
    run_frame(4'hA, 4'h3, 3'd2, {48'h0, 16'h5A3C, 16'hF00D}, 8'hC5, 1'b0, 1'b0, "R3 R5 single");
    // R6 R7: dual lane, alternating patterns
    run_frame(4'h5, 4'hC, 3'd2, {48'h0, 16'hAAAA, 16'h5555}, 8'h96, 1'b1, 1'b0, "R6 R7 dual");
    // R9: zero words, both modes
    run_frame(4'h0, 4'hF, 3'd0, '0, 8'h00, 1'b0, 1'b0, "R9 zero single");
    run_frame(4'hF, 4'h0, 3'd0, '0, 8'hFF, 1'b1, 1'b0, "R9 zero dual");
    // R9: full and clamped counts
    run_frame(4'h6, 4'h9, 3'd5, rnd_data(), 8'h3B, 1'b1, 1'b0, "R9 full dual");
    run_frame(4'h1, 4'h2, 3'd7, rnd_data(), 8'h81, 1'b0, 1'b0, "R9 clamp7 single");
    run_frame(4'h7, 4'hE, 3'd6, rnd_data(), 8'h42, 1'b1, 1'b0, "R9 clamp6 dual");
    // R8: changes during the frame ignored
    run_frame(4'h9, 4'h4, 3'd3, rnd_data(), 8'hE7, 1'b1, 1'b1, "R8 disturb dual");
    run_frame(4'h2, 4'hB, 3'd1, rnd_data(), 8'h18, 1'b0, 1'b1, "R8 disturb single");

    // random frames, R3 R5 R6 R7 R9
    for (int n = 0; n < 24; n++) begin
      logic [3:0] ty, tg;
      logic [NWW-1:0] nw;
      logic [7:0] cr;
      bit md;
      ty = 4'($urandom()); tg = 4'($urandom()); nw = NWW'($urandom());
      cr = 8'($urandom()); md = 1'($urandom());
      run_frame(ty, tg, nw, rnd_data(), cr, md, 1'($urandom_range(0, 3) == 0),
                md ? "R6 R7 random dual" : "R5 random single");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule